// File: doc/BRIEF.md
# Quadrature Correlation Accumulator

This block correlates one detrended intensity profile with a sine reference and a cosine reference at a fixed spatial frequency. It returns the two correlation sums, Is (samples weighted by the sine reference) and Ic (samples weighted by the cosine reference), once the last pixel of the profile has gone through. The references are held in two per-pixel coefficient tables. Control logic loads them once, after a calibration step has found the frequency and before the acquisition loop starts. During acquisition the tables are only read.

Each sample arrives with its pixel position. That position selects the sine and cosine coefficients. The two products are formed in parallel behind a registered multiplier stage, at one sample per clock, and are summed at full precision. A marker on the final sample closes the profile. A single-cycle valid pulse then presents both sums, and the sums stay on the outputs until the next profile finishes. Computing the coefficients and extracting a phase from the two sums are done elsewhere.

Top module: `quad_corr_acc`

## Requirements
- R1: A table write (`tbl_we_i` high) stores the pair `tbl_sin_i`/`tbl_cos_i` at entry `tbl_addr_i`, provided the block is idle and `tbl_addr_i` < NUM_PIX (24 by default). A write to an address at or beyond NUM_PIX changes no entry.
- R2: Samples and coefficients are signed two's complement. `res_is_o` is the exact sum of sample × sine entry over the profile, and `res_ic_o` is the exact sum of sample × cosine entry, with no rounding.
- R3: The sums are ACC_W bits wide (37 by default). They hold NUM_PIX full-scale products without overflow, including the case where every product is (−32768)×(−32768).
- R4: Every profile starts from zero. A result depends only on that profile's own samples, including when a profile begins on the cycle right after the previous profile's last sample.
- R5: When the last sample is captured on clock edge n, `res_valid_o` is high from edge n+2 to edge n+3. There is exactly one pulse per profile.
- R6: `res_is_o` and `res_ic_o` change only in a cycle where `res_valid_o` is high, and otherwise keep the last result.
- R7: A table write is ignored from the cycle that presents a profile's first sample until its last product has been summed. Later profiles still see the old coefficients.
- R8: A sample whose `smp_idx_i` is NUM_PIX or larger contributes zero to both sums.
- R9: Cycles with `smp_valid_i` low inside a profile add nothing. A profile may be a single sample, with `smp_last_i` set on its first sample.
- R10: After reset `res_valid_o` is low, both sums read zero, and every table entry is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tbl_we_i | input | 1 | Table write strobe |
| tbl_addr_i | input | IDX_W | Table entry (pixel position) to write |
| tbl_sin_i | input | COEF_W | Sine coefficient to store |
| tbl_cos_i | input | COEF_W | Cosine coefficient to store |
| smp_valid_i | input | 1 | Sample present this cycle |
| smp_last_i | input | 1 | Sample is the last of its profile |
| smp_idx_i | input | IDX_W | Pixel position of the sample |
| smp_data_i | input | SAMPLE_W | Detrended sample, signed |
| res_valid_o | output | 1 | One-cycle pulse when a result is ready |
| res_is_o | output | ACC_W | Sum of sample × sine coefficient, signed |
| res_ic_o | output | ACC_W | Sum of sample × cosine coefficient, signed |

## Verification
The case hardest to reach from the ports is a table write that arrives while a profile is in flight. Its effect is invisible at the moment it happens and can only show up in later sums. The stimulus issues the write partway through a profile, aimed at an entry the same profile reads afterwards. It then runs a second profile over that entry with no further write, and only after that repeats the write with the block idle, so that the sums show the old value twice and the new value once. Two related cases get the same treatment. Back-to-back profiles, with the first sample directly after a last sample, test the clearing between profiles. Full-scale tables with full-scale samples drive the sums to their largest magnitude, in both signs.

// File: rtl/qca_pkg.sv
`timescale 1ns/1ps
package qca_pkg;
  localparam int NUM_LANE = 2;
  localparam int LANE_SIN = 0;
  localparam int LANE_COS = 1;

  typedef struct packed {
    logic vld;
    logic first;
    logic last;
  } tag_t;
endpackage

// File: rtl/qca_seq.sv
`timescale 1ns/1ps
module qca_seq
  import qca_pkg::*;
#(
  parameter int NUM_PIX = 24,
  parameter int IDX_W   = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             smp_valid_i,
  input  logic             smp_last_i,
  input  logic             tbl_we_i,
  input  logic [IDX_W-1:0] tbl_addr_i,
  output tag_t             tag_a_o,
  output tag_t             tag_b_o,
  output logic             tbl_wr_en_o,
  output logic             res_valid_o
);
  logic open_q;
  tag_t tag_d;
  logic busy;
  logic addr_ok;

  always_comb begin
    tag_d.vld   = smp_valid_i;
    tag_d.first = smp_valid_i & ~open_q;
    tag_d.last  = smp_valid_i & smp_last_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q      <= 1'b0;
      tag_a_o     <= '0;
      tag_b_o     <= '0;
      res_valid_o <= 1'b0;
    end else begin
      if (smp_valid_i) open_q <= ~smp_last_i;
      tag_a_o     <= tag_d;
      tag_b_o     <= tag_a_o;
      res_valid_o <= tag_b_o.vld & tag_b_o.last;
    end
  end

  // profile in flight until its last product is summed
  assign busy        = smp_valid_i | open_q | tag_a_o.vld | tag_b_o.vld;
  assign addr_ok     = int'(tbl_addr_i) < NUM_PIX;
  assign tbl_wr_en_o = tbl_we_i & ~busy & addr_ok;
endmodule

// File: rtl/qca_coef_table.sv
`timescale 1ns/1ps
module qca_coef_table
  import qca_pkg::*;
#(
  parameter int NUM_PIX = 24,
  parameter int IDX_W   = 5,
  parameter int COEF_W  = 16
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             wr_en_i,
  input  logic [IDX_W-1:0]                 wr_addr_i,
  input  logic [NUM_LANE-1:0][COEF_W-1:0]  wr_coef_i,
  input  logic                             rd_en_i,
  input  logic [IDX_W-1:0]                 rd_idx_i,
  output logic [NUM_LANE-1:0][COEF_W-1:0]  rd_coef_o
);
  logic [NUM_LANE-1:0][COEF_W-1:0] mem_q [NUM_PIX];
  logic                            rd_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int e = 0; e < NUM_PIX; e++) mem_q[e] <= '0;
    end else if (wr_en_i) begin
      for (int e = 0; e < NUM_PIX; e++)
        if (int'(wr_addr_i) == e) mem_q[e] <= wr_coef_i;
    end
  end

  assign rd_ok = int'(rd_idx_i) < NUM_PIX;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_coef_o <= '0;
    end else if (rd_en_i) begin
      rd_coef_o <= '0;
      for (int e = 0; e < NUM_PIX; e++)
        if (rd_ok && int'(rd_idx_i) == e) rd_coef_o <= mem_q[e];
    end
  end
endmodule

// File: rtl/qca_mac_lane.sv
`timescale 1ns/1ps
module qca_mac_lane
  import qca_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int COEF_W   = 16,
  parameter int ACC_W    = 37,
  localparam int PROD_W  = SAMPLE_W + COEF_W
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic signed [SAMPLE_W-1:0] smp_i,
  input  logic signed [COEF_W-1:0]   coef_i,
  input  tag_t                       tag_a_i,
  input  tag_t                       tag_b_i,
  output logic        [ACC_W-1:0]    res_o
);
  logic signed [PROD_W-1:0] prod_q;
  logic        [ACC_W-1:0]  prod_x;
  logic        [ACC_W-1:0]  acc_q;
  logic        [ACC_W-1:0]  sum;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          prod_q <= '0;
    else if (tag_a_i.vld) prod_q <= smp_i * coef_i;
  end

  assign prod_x = {{(ACC_W-PROD_W){prod_q[PROD_W-1]}}, prod_q};
  // first product of a profile replaces the running sum
  assign sum    = tag_b_i.first ? prod_x : acc_q + prod_x;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      res_o <= '0;
    end else if (tag_b_i.vld) begin
      acc_q <= sum;
      if (tag_b_i.last) res_o <= sum;
    end
  end
endmodule

// File: rtl/quad_corr_acc.sv
`timescale 1ns/1ps
module quad_corr_acc
  import qca_pkg::*;
#(
  parameter int  SAMPLE_W = 16,
  parameter int  COEF_W   = 16,
  parameter int  NUM_PIX  = 24,
  localparam int IDX_W    = (NUM_PIX > 1) ? $clog2(NUM_PIX) : 1,
  localparam int PROD_W   = SAMPLE_W + COEF_W,
  localparam int ACC_W    = PROD_W + $clog2(NUM_PIX + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tbl_we_i,
  input  logic [IDX_W-1:0]    tbl_addr_i,
  input  logic [COEF_W-1:0]   tbl_sin_i,
  input  logic [COEF_W-1:0]   tbl_cos_i,
  input  logic                smp_valid_i,
  input  logic                smp_last_i,
  input  logic [IDX_W-1:0]    smp_idx_i,
  input  logic [SAMPLE_W-1:0] smp_data_i,
  output logic                res_valid_o,
  output logic [ACC_W-1:0]    res_is_o,
  output logic [ACC_W-1:0]    res_ic_o
);
  tag_t                            tag_a;
  tag_t                            tag_b;
  logic                            tbl_wr_en;
  logic [NUM_LANE-1:0][COEF_W-1:0] wr_coef;
  logic [NUM_LANE-1:0][COEF_W-1:0] coef_q;
  logic [SAMPLE_W-1:0]             smp_q;
  logic [NUM_LANE-1:0][ACC_W-1:0]  lane_res;

  assign wr_coef[LANE_SIN] = tbl_sin_i;
  assign wr_coef[LANE_COS] = tbl_cos_i;

  qca_seq #(
    .NUM_PIX(NUM_PIX),
    .IDX_W  (IDX_W)
  ) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .smp_valid_i(smp_valid_i),
    .smp_last_i (smp_last_i),
    .tbl_we_i   (tbl_we_i),
    .tbl_addr_i (tbl_addr_i),
    .tag_a_o    (tag_a),
    .tag_b_o    (tag_b),
    .tbl_wr_en_o(tbl_wr_en),
    .res_valid_o(res_valid_o)
  );

  qca_coef_table #(
    .NUM_PIX(NUM_PIX),
    .IDX_W  (IDX_W),
    .COEF_W (COEF_W)
  ) u_tbl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (tbl_wr_en),
    .wr_addr_i(tbl_addr_i),
    .wr_coef_i(wr_coef),
    .rd_en_i  (smp_valid_i),
    .rd_idx_i (smp_idx_i),
    .rd_coef_o(coef_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          smp_q <= '0;
    else if (smp_valid_i) smp_q <= smp_data_i;
  end

  for (genvar g = 0; g < NUM_LANE; g++) begin : g_lane
    qca_mac_lane #(
      .SAMPLE_W(SAMPLE_W),
      .COEF_W  (COEF_W),
      .ACC_W   (ACC_W)
    ) u_mac (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .smp_i  (smp_q),
      .coef_i (coef_q[g]),
      .tag_a_i(tag_a),
      .tag_b_i(tag_b),
      .res_o  (lane_res[g])
    );
  end

  assign res_is_o = lane_res[LANE_SIN];
  assign res_ic_o = lane_res[LANE_COS];
endmodule

// File: rtl/quad_corr_acc_chk.sv
`timescale 1ns/1ps
module quad_corr_acc_chk #(
  parameter int NUM_PIX = 24,
  parameter int IDX_W   = 5,
  parameter int ACC_W   = 37
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tbl_we_i,
  input logic [IDX_W-1:0] tbl_addr_i,
  input logic             smp_valid_i,
  input logic             smp_last_i,
  input logic             tbl_wr_en,
  input logic             res_valid_o,
  input logic [ACC_W-1:0] res_is_o,
  input logic [ACC_W-1:0] res_ic_o
);
  logic [1:0] age_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  assert_res_latency_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 2'd3 && $past(smp_valid_i && smp_last_i, 3)) |-> res_valid_o);

  assert_res_origin_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 2'd3 && res_valid_o) |-> $past(smp_valid_i && smp_last_i, 3));

  assert_res_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q != 2'd0 && !res_valid_o) |-> ($stable(res_is_o) && $stable(res_ic_o)));

  assert_no_write_busy_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tbl_we_i && smp_valid_i) |-> !tbl_wr_en);

  assert_write_range_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tbl_wr_en |-> (tbl_we_i && int'(tbl_addr_i) < NUM_PIX));
endmodule

bind quad_corr_acc quad_corr_acc_chk #(
  .NUM_PIX(NUM_PIX),
  .IDX_W  (IDX_W),
  .ACC_W  (ACC_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tbl_we_i   (tbl_we_i),
  .tbl_addr_i (tbl_addr_i),
  .smp_valid_i(smp_valid_i),
  .smp_last_i (smp_last_i),
  .tbl_wr_en  (tbl_wr_en),
  .res_valid_o(res_valid_o),
  .res_is_o   (res_is_o),
  .res_ic_o   (res_ic_o)
);

// File: tb/quad_corr_acc_bench.sv
`timescale 1ns/1ps
module quad_corr_acc_bench;
  localparam int NPIX = 24;
  localparam int IW   = 5;
  localparam int AW   = 37;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tbl_we = 1'b0;
  logic [IW-1:0] tbl_addr = '0;
  logic [15:0] tbl_sin = '0;
  logic [15:0] tbl_cos = '0;
  logic smp_valid = 1'b0;
  logic smp_last = 1'b0;
  logic [IW-1:0] smp_idx = '0;
  logic [15:0] smp_data = '0;
  logic res_valid;
  logic [AW-1:0] res_is;
  logic [AW-1:0] res_ic;

  always #5 clk = ~clk;

  quad_corr_acc u_quad_corr_acc (
    .clk_i(clk), .rst_ni(rst_n),
    .tbl_we_i(tbl_we), .tbl_addr_i(tbl_addr), .tbl_sin_i(tbl_sin), .tbl_cos_i(tbl_cos),
    .smp_valid_i(smp_valid), .smp_last_i(smp_last), .smp_idx_i(smp_idx), .smp_data_i(smp_data),
    .res_valid_o(res_valid), .res_is_o(res_is), .res_ic_o(res_ic)
  );

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 1'b0;

  // model of table contents
  logic signed [15:0] m_sin [NPIX];
  logic signed [15:0] m_cos [NPIX];

  // profile description
  int pd_n;
  logic signed [15:0] pd_smp [64];
  int pd_idx [64];
  bit pd_gap [64];
  bit pd_we [64];
  int pd_waddr [64];
  logic [15:0] pd_wsin [64];
  logic [15:0] pd_wcos [64];

  // result log
  int res_n = 0;
  longint log_is [64];
  longint log_ic [64];
  int log_cyc [64];

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (res_valid && res_n < 64) begin
      log_is[res_n]  = longint'($signed(res_is));
      log_ic[res_n]  = longint'($signed(res_ic));
      log_cyc[res_n] = cyc;
      res_n++;
    end
  end

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  task automatic clear_pd();
    pd_n = 0;
    for (int k = 0; k < 64; k++) begin
      pd_gap[k] = 0; pd_we[k] = 0; pd_waddr[k] = 0; pd_wsin[k] = '0; pd_wcos[k] = '0;
      pd_idx[k] = 0; pd_smp[k] = '0;
    end
  endtask

  task automatic load_entry(input int addr, input logic [15:0] s, input logic [15:0] c, input bit accept);
    tbl_we = 1'b1; tbl_addr = IW'(addr); tbl_sin = s; tbl_cos = c;
    @(negedge clk);
    tbl_we = 1'b0;
    if (accept) begin m_sin[addr] = s; m_cos[addr] = c; end
  endtask

  task automatic load_pattern();
    for (int i = 0; i < NPIX; i++)
      load_entry(i, 16'(i * 2731 - 30000), 16'(25000 - i * 1999), 1'b1);
  endtask

  task automatic drive_profile(output longint e_is, output longint e_ic, output int last_cyc);
    e_is = 0; e_ic = 0; last_cyc = 0;
    for (int k = 0; k < pd_n; k++) begin
      if (pd_gap[k]) begin
        smp_valid = 1'b0; smp_last = 1'b0; tbl_we = 1'b0;
        @(negedge clk);
      end
      smp_valid = 1'b1;
      smp_last  = (k == pd_n - 1);
      smp_idx   = IW'(pd_idx[k]);
      smp_data  = pd_smp[k];
      tbl_we    = pd_we[k];
      tbl_addr  = IW'(pd_waddr[k]);
      tbl_sin   = pd_wsin[k];
      tbl_cos   = pd_wcos[k];
      if (pd_idx[k] < NPIX) begin
        e_is += longint'(pd_smp[k]) * longint'(m_sin[pd_idx[k]]);
        e_ic += longint'(pd_smp[k]) * longint'(m_cos[pd_idx[k]]);
      end
      @(negedge clk);
      last_cyc = cyc;
    end
    smp_valid = 1'b0; smp_last = 1'b0; tbl_we = 1'b0;
  endtask

  task automatic chk_res(input int k, input longint e_is, input longint e_ic, input int lcyc, input string req);
    chk(req, "result present", longint'(res_n > k), 1);
    if (res_n > k) begin
      chk(req, "Is", log_is[k], e_is);
      chk(req, "Ic", log_ic[k], e_ic);
      chk("R5", "valid cycle", longint'(log_cyc[k]), longint'(lcyc + 2));
    end
  endtask

  task automatic run_one(input string req);
    longint ei, ec; int lc; int base;
    base = res_n;
    drive_profile(ei, ec, lc);
    repeat (5) @(negedge clk);
    chk("R5", "one pulse per profile", longint'(res_n - base), 1);
    chk_res(base, ei, ec, lc, req);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10", "valid in reset", longint'(res_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10", "valid after reset", longint'(res_valid), 0);
    chk("R10", "Is after reset", longint'(res_is), 0);
    chk("R10", "Ic after reset", longint'(res_ic), 0);
    for (int i = 0; i < NPIX; i++) begin m_sin[i] = '0; m_cos[i] = '0; end
    clear_pd();
    pd_n = NPIX;
    for (int k = 0; k < NPIX; k++) begin pd_idx[k] = k; pd_smp[k] = 16'(1000 + k * 333); end
    run_one("R10");
  endtask

  task automatic t_basic();
    longint hi, hc;
    load_pattern();
    clear_pd();
    pd_n = 20;
    for (int k = 0; k < 20; k++) begin pd_idx[k] = k; pd_smp[k] = 16'(k * 977 - 9000); end
    run_one("R2");
    hi = longint'($signed(res_is)); hc = longint'($signed(res_ic));
    repeat (7) @(negedge clk);
    chk("R6", "Is held", longint'($signed(res_is)), hi);
    chk("R6", "Ic held", longint'($signed(res_ic)), hc);
    // reversed index order
    clear_pd();
    pd_n = 24;
    for (int k = 0; k < 24; k++) begin pd_idx[k] = 23 - k; pd_smp[k] = 16'(20000 - k * 1711); end
    run_one("R2");
  endtask

  task automatic t_fullscale();
    longint ei0, ec0, ei1, ec1; int lc0, lc1; int base;
    for (int i = 0; i < NPIX; i++) load_entry(i, 16'h8000, 16'h8000, 1'b1);
    base = res_n;
    clear_pd();
    pd_n = NPIX;
    for (int k = 0; k < NPIX; k++) begin pd_idx[k] = k; pd_smp[k] = 16'h8000; end
    drive_profile(ei0, ec0, lc0);
    for (int k = 0; k < NPIX; k++) pd_smp[k] = 16'h7fff;
    drive_profile(ei1, ec1, lc1);
    repeat (5) @(negedge clk);
    chk("R3", "full-scale Is model", ei0, longint'(NPIX) * 64'sd1073741824);
    chk_res(base, ei0, ec0, lc0, "R3");
    chk_res(base + 1, ei1, ec1, lc1, "R4");
    chk("R3", "negative full-scale", ei1, longint'(NPIX) * 32767 * -32768);
    load_pattern();
  endtask

  task automatic t_gap_single();
    clear_pd();
    pd_n = 10;
    for (int k = 0; k < 10; k++) begin pd_idx[k] = 3 + k; pd_smp[k] = 16'(-7000 + k * 1500); pd_gap[k] = (k % 3 == 1); end
    pd_gap[9] = 1;
    run_one("R9");
    clear_pd();
    pd_n = 1; pd_idx[0] = 17; pd_smp[0] = 16'(-12345);
    run_one("R9");
  endtask

  task automatic t_oob();
    clear_pd();
    pd_n = 8;
    for (int k = 0; k < 8; k++) begin pd_smp[k] = 16'(3000 + k * 2100); pd_idx[k] = (k % 2 == 0) ? k : 24 + k; end
    pd_idx[7] = 31;
    run_one("R8");
    load_entry(30, 16'h1234, 16'h4321, 1'b0);
    clear_pd();
    pd_n = NPIX;
    for (int k = 0; k < NPIX; k++) begin pd_idx[k] = k; pd_smp[k] = 16'(500 + k * 97); end
    run_one("R1");
  endtask

  task automatic t_write_during();
    clear_pd();
    pd_n = 12;
    for (int k = 0; k < 12; k++) begin pd_idx[k] = k; pd_smp[k] = 16'(4000 - k * 650); end
    pd_we[3] = 1; pd_waddr[3] = 10; pd_wsin[3] = 16'h7000; pd_wcos[3] = 16'h9000;
    run_one("R7");
    clear_pd();
    pd_n = 2; pd_idx[0] = 10; pd_smp[0] = 16'd1111; pd_idx[1] = 11; pd_smp[1] = 16'(-2222);
    run_one("R7");
    load_entry(10, 16'h7000, 16'h9000, 1'b1);
    run_one("R1");
  endtask

  initial begin
    t_reset();
    t_basic();
    t_fullscale();
    t_gap_single();
    t_oob();
    t_write_during();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL all-R watchdog act=timeout exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule